// File: doc/BRIEF.md
# Interrupt Pending and Enable Register

This block holds the interrupt state for five sources: external, timer 1, timer 2, asynchronous serial and synchronous serial. Each source sends a one-cycle request pulse. The pulse sets a pending latch for that source. The latch stays set until software clears it.

Software sees one 16-bit register address, but reads and writes use different storage. A write to the low byte loads the per-source enable bits. A write to the high byte is a set of strobes: writing a 1 in a source's bit clears that source's pending latch. A read returns the enable bits in the low byte and the pending latches in the high byte.

The interrupt output is a single registered line. It is high when any source is both pending and enabled.

Top module: `irq_pend_reg`

## Requirements
- R1: After reset, `rd_data` reads 0 and `irq` is low.
- R2: A write with `wr_be[0]` set loads the enables from `wr_data[4:0]`, and `rd_data[4:0]` shows the new value in the next cycle. The bit order is: bit 0 external, bit 1 timer 1, bit 2 timer 2, bit 3 asynchronous serial, bit 4 synchronous serial.
- R3: A write with `wr_be[1]` set and a 1 in `wr_data[8+i]` clears pending latch i by the next cycle. A 0 in that bit leaves the latch unchanged. The source order is the same as in R2.
- R4: The byte lanes act independently. A high-byte-only write leaves the enables unchanged. A low-byte-only write clears no pending latch, whatever its upper data bits hold.
- R5: A pulse on `src_req[i]` sets pending latch i in the next cycle, whether or not source i is enabled. The latch then holds until it is cleared.
- R6: `rd_data` is laid out as follows: bits 12:8 hold the pending latches, bits 4:0 hold the enables, and bits 15:13 and 7:5 read 0. The clear strobes are never stored, so they never appear on a read.
- R7: When a request and a clear for the same source arrive in the same cycle, the request wins and the latch stays set.
- R8: `irq` is registered. In each cycle it equals the OR, over all sources, of pending AND enable as they stood in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte lane enables: bit 0 is the low byte, bit 1 is the high byte |
| wr_data | input | 16 | Write data: enables in the low byte, clear strobes in the high byte |
| src_req | input | 5 | One-cycle request pulses, one per source |
| rd_data | output | 16 | Read word: pending latches and enables |
| irq | output | 1 | Registered interrupt output |

## Verification
A wrong pending or enable bit shows on `rd_data` in the cycle right after the edge that stored it, because the read path is combinational from the state. The same fault reaches `irq` one cycle later. Each cycle, the bench compares both outputs with a behavioural model. Directed sequences target byte-lane isolation, clear-versus-request collisions and zero-valued clears, where a mistake would otherwise hide among ordinary traffic.

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N_SRC    = 5,
  parameter int DATA_W   = 16,
  parameter int CLR_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_SRC-1:0]  src_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  logic [N_SRC-1:0] pend_q, ena_q, clr_stb;
  logic             irq_q;

  assign clr_stb = (wr_en && wr_be[1]) ? wr_data[CLR_BASE +: N_SRC] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ena_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_stb) | src_req;
      if (wr_en && wr_be[0]) ena_q <= wr_data[N_SRC-1:0];
      irq_q  <= |(pend_q & ena_q);
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[N_SRC-1:0]         = ena_q;
    rd_data[CLR_BASE +: N_SRC] = pend_q;
  end

  assign irq = irq_q;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && ((wr_data[CLR_BASE +: N_SRC] & ~src_req) != '0))
    |=> ((rd_data[CLR_BASE +: N_SRC] & $past(wr_data[CLR_BASE +: N_SRC] & ~src_req)) == '0)); // R3

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((rd_data[CLR_BASE +: N_SRC] & $past(src_req)) == $past(src_req))); // R5

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be[0]) |=> $stable(rd_data[N_SRC-1:0])); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((rd_data[CLR_BASE +: N_SRC] & rd_data[N_SRC-1:0]) != '0)); // R8

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[CLR_BASE +: N_SRC] & rd_data[N_SRC-1:0]) != '0) |=> irq); // R8

endmodule

// File: tb/irq_pend_reg_tb.sv
`timescale 1ns/1ps
module irq_pend_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [4:0]  src_req;
  logic [15:0] rd_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [4:0] m_pend, m_en;
  logic       m_irq;

  always #4 clk = ~clk;

  irq_pend_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .src_req(src_req), .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 5'd0; m_en <= 5'd0; m_irq <= 1'b0;
    end else begin
      m_irq <= (m_pend & m_en) != 5'd0;
      for (int i = 0; i < 5; i++) begin
        if (src_req[i]) m_pend[i] <= 1'b1;
        else if (wr_en && wr_be[1] && wr_data[8+i]) m_pend[i] <= 1'b0;
      end
      if (wr_en && wr_be[0]) m_en <= wr_data[4:0];
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    chk("R5 pending field", {11'd0, rd_data[12:8]}, {11'd0, m_pend});
    chk("R2 enable field", {11'd0, rd_data[4:0]}, {11'd0, m_en});
    chk("R6 unused bits", {10'd0, rd_data[15:13], rd_data[7:5]}, 16'd0);
    chk("R8 irq", {15'd0, irq}, {15'd0, m_irq});
  endtask

  task automatic step(input logic we, input logic [1:0] be, input logic [15:0] d, input logic [4:0] rq);
    wr_en = we; wr_be = be; wr_data = d; src_req = rq;
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0; src_req = 5'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset read", rd_data, 16'h0000);
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);

    step(1, 2'b01, 16'h001F, 5'h00);
    chk("R2 enables loaded", rd_data, 16'h001F);
    step(0, 2'b00, 16'h0000, 5'b00101);
    chk("R5 requests latched", rd_data, 16'h051F);
    step(0, 2'b00, 16'h0000, 5'h00);
    chk("R8 irq follows", {15'd0, irq}, 16'h0001);
    step(1, 2'b10, 16'h01FF, 5'h00);
    chk("R3 clear bit 8", rd_data, 16'h041F);
    chk("R4 high lane keeps enables", {11'd0, rd_data[4:0]}, 16'h001F);
    step(1, 2'b01, 16'h1F03, 5'h00);
    chk("R4 low lane clears nothing", rd_data, 16'h0403);
    step(1, 2'b10, 16'h0400, 5'b00100);
    chk("R7 request beats clear", rd_data, 16'h0403);
    step(1, 2'b10, 16'h0000, 5'h00);
    chk("R3 zero clear no effect", rd_data, 16'h0403);
    step(0, 2'b00, 16'h0000, 5'b10000);
    chk("R5 disabled source pends", rd_data, 16'h1403);
    step(1, 2'b11, 16'h1F00, 5'h00);
    chk("R3 clear all and disable", rd_data, 16'h0000);
    step(0, 2'b00, 16'h0000, 5'h00);
    chk("R8 irq drops", {15'd0, irq}, 16'h0000);

    for (int n = 0; n < 400; n++) begin
      logic [4:0] rq;
      rq = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h00;
      step(1'($urandom), 2'($urandom), 16'($urandom), rq);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule